// File: doc/BRIEF.md
# Multi-Mode Cache Module Latency Controller

This block fronts a single-ported 8 KB L1 data-cache module that can run in one of three power states: a fast state, a slow low-energy state and a switched-off state. It accepts one read or write at a time. It returns the response after the access latency of the current state, and it answers every request with an error while the module is switched off. Responses carry a valid pulse, read data and the tag of the request. Because only one access is ever in flight, responses come back in request order.

A privileged control port selects the state, typically when the operating system switches context. A state change waits until any access in flight has finished. The change is then applied with a fixed reconfiguration blackout, during which new requests are held off by a low ready. Turning the module back on from the off state discards its contents. The storage is a behavioural word array with one valid bit per word.

Top module: `cache_mode_ctrl`

## Requirements
- R1: After reset the module is in the fast state, `req_ready` is high and `rsp_valid` is low.
- R2: In the fast state, a request accepted on clock edge N gives a one-cycle `rsp_valid` pulse after edge N+2, with `rsp_err` low.
- R3: In the slow state, a request accepted on edge N gives its response after edge N+4.
- R4: Only one access is in flight. `req_ready` stays low from acceptance until the response cycle, and it is high again in the response cycle.
- R5: A write (`req_write`=1) stores `req_wdata` at word `req_addr` and its response has `rsp_rdata`=0. A read returns the last data written to that word. Every response echoes `req_tag` on `rsp_tag`.
- R6: In the off state `req_ready` stays low. A request presented while the block is idle in that state gets a response with `rsp_err`=1, `rsp_rdata`=0 and its tag one cycle later.
- R7: A mode command is registered on the edge that samples `cfg_valid`. `req_ready` is then low for three cycles: one cycle to register the command and a two-cycle blackout. After that the new latency applies.
- R8: A request presented during the blackout is held and is served correctly once ready returns.
- R9: A mode command that arrives while an access is in flight leaves that access at the old latency. The blackout begins after the response.
- R10: Mode code 2'b11 is ignored: there is no blackout and the latency does not change. The codes are 2'b00 off, 2'b01 fast and 2'b10 slow.
- R11: A read of a word that has not been written since reset, or since the last switch from off to on, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Mode command strobe from the privileged port |
| cfg_mode | input | 2 | Requested mode: 00 off, 01 fast, 10 slow, 11 ignored |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when high together with req_valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 11 | Word address |
| req_wdata | input | 32 | Write data |
| req_tag | input | 4 | Request tag |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Request rejected because the module is off |
| rsp_rdata | output | 32 | Read data, 0 for writes and errors |
| rsp_tag | output | 4 | Echo of the request tag |

## Verification
Reads and writes are run in both active modes. Measuring the number of edges from acceptance to response separates the fast latency from the slow one and from an off-by-one counter. Mode commands are sent in four situations: while the block is idle, while an access is in flight, with the reserved code, and into the off state and back. The wait before the next acceptance shows whether the blackout has the right length and whether it was deferred or suppressed. Reading data written before an off period back after it, and reading a word never written, tells retained contents apart from invalidated ones.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
    localparam logic [1:0] MODE_OFF  = 2'b00;
    localparam logic [1:0] MODE_FAST = 2'b01;
    localparam logic [1:0] MODE_SLOW = 2'b10;
    localparam logic [1:0] MODE_RSVD = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUSY  = 2'd1,
        ST_RECFG = 2'd2,
        ST_ERR   = 2'd3
    } ctl_state_e;
endpackage

// File: rtl/cmc_cfg_latch.sv
module cmc_cfg_latch import cmc_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_valid,
    input  logic [1:0] cfg_mode,
    input  logic       take,
    output logic       pend,
    output logic [1:0] pend_mode
);
    typedef struct packed {
        logic       pend;
        logic [1:0] mode;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (take) begin
            cfg_d.pend = 1'b0;
        end
        // a newer legal command overrides whatever is still pending
        if (cfg_valid && (cfg_mode != MODE_RSVD)) begin
            cfg_d.pend = 1'b1;
            cfg_d.mode = cfg_mode;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign pend      = cfg_q.pend;
    assign pend_mode = cfg_q.mode;
endmodule

// File: rtl/cmc_store.sv
module cmc_store #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 2048,
    localparam int ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              inval_all,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [WORDS];
    logic [WORDS-1:0]  vld_d, vld_q;

    always_comb begin
        vld_d = vld_q;
        if (inval_all) begin
            vld_d = '0;
        end else if (en && we) begin
            vld_d[addr] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= vld_d;
        end
    end

    always_ff @(posedge clk) begin
        if (en && we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = vld_q[addr] ? mem_q[addr] : '0;
endmodule

// File: rtl/cache_mode_ctrl.sv
module cache_mode_ctrl import cmc_pkg::*; #(
    parameter int DATA_W    = 32,
    parameter int CAP_BYTES = 8192,
    parameter int TAG_W     = 4,
    parameter int FAST_LAT  = 2,
    parameter int SLOW_LAT  = 4,
    parameter int RECFG_CYC = 2,
    localparam int WORDS  = CAP_BYTES / (DATA_W / 8),
    localparam int ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [1:0]        cfg_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [TAG_W-1:0]  rsp_tag
);
    localparam int MAX_LAT = (SLOW_LAT > FAST_LAT) ? SLOW_LAT : FAST_LAT;
    localparam int MAX_CNT = (MAX_LAT > RECFG_CYC) ? MAX_LAT : RECFG_CYC;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    typedef struct packed {
        ctl_state_e        st;
        logic [1:0]        mode;
        logic [CNT_W-1:0]  cnt;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [TAG_W-1:0]  tag;
        logic              rv;
        logic              rerr;
        logic [DATA_W-1:0] rdata;
        logic [TAG_W-1:0]  rtag;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              pend;
    logic [1:0]        pend_mode;
    logic              take;
    logic              st_en;
    logic              inval;
    logic [DATA_W-1:0] st_rdata;

    cmc_cfg_latch u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_valid (cfg_valid),
        .cfg_mode  (cfg_mode),
        .take      (take),
        .pend      (pend),
        .pend_mode (pend_mode)
    );

    cmc_store #(
        .DATA_W (DATA_W),
        .WORDS  (WORDS)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (st_en),
        .we        (ctl_q.we),
        .addr      (ctl_q.addr),
        .wdata     (ctl_q.wdata),
        .inval_all (inval),
        .rdata     (st_rdata)
    );

    assign req_ready = (ctl_q.st == ST_IDLE) && !pend && (ctl_q.mode != MODE_OFF);

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.rv   = 1'b0;
        ctl_d.rerr = 1'b0;
        take       = 1'b0;
        st_en      = 1'b0;
        inval      = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (pend) begin
                    take       = 1'b1;
                    ctl_d.st   = ST_RECFG;
                    ctl_d.mode = pend_mode;
                    ctl_d.cnt  = CNT_W'(RECFG_CYC - 1);
                    inval      = (ctl_q.mode == MODE_OFF) && (pend_mode != MODE_OFF);
                end else if (req_valid && (ctl_q.mode == MODE_OFF)) begin
                    ctl_d.st    = ST_ERR;
                    ctl_d.rv    = 1'b1;
                    ctl_d.rerr  = 1'b1;
                    ctl_d.rdata = '0;
                    ctl_d.rtag  = req_tag;
                end else if (req_valid) begin
                    ctl_d.st    = ST_BUSY;
                    ctl_d.we    = req_write;
                    ctl_d.addr  = req_addr;
                    ctl_d.wdata = req_wdata;
                    ctl_d.tag   = req_tag;
                    ctl_d.cnt   = (ctl_q.mode == MODE_SLOW) ? CNT_W'(SLOW_LAT - 1)
                                                            : CNT_W'(FAST_LAT - 1);
                end
            end
            ST_BUSY: begin
                if (ctl_q.cnt == '0) begin
                    st_en       = 1'b1;
                    ctl_d.st    = ST_IDLE;
                    ctl_d.rv    = 1'b1;
                    ctl_d.rdata = ctl_q.we ? '0 : st_rdata;
                    ctl_d.rtag  = ctl_q.tag;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_RECFG: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st = ST_IDLE;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_ERR: begin
                ctl_d.st = ST_IDLE;
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_IDLE;
            ctl_q.mode <= MODE_FAST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rsp_valid = ctl_q.rv;
    assign rsp_err   = ctl_q.rerr;
    assign rsp_rdata = ctl_q.rdata;
    assign rsp_tag   = ctl_q.rtag;
endmodule

// File: rtl/cmc_mode_ctrl_chk.sv
module cmc_mode_ctrl_chk #(
    parameter int TAG_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [TAG_W-1:0] req_tag,
    input logic             rsp_valid,
    input logic             rsp_err,
    input logic [TAG_W-1:0] rsp_tag
);
    logic [TAG_W-1:0] acc_tag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_tag_q <= '0;
        end else if (req_valid && req_ready) begin
            acc_tag_q <= req_tag;
        end
    end

    // R6: an error is always delivered as a response
    a_r6_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);

    // R6: an error response echoes the tag presented on the cycle before
    a_r6_err_tag: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_tag == $past(req_tag)));

    // R4: responses are single-cycle pulses
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R4: no second acceptance directly after one
    a_r4_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2: a response never appears on the cycle right after acceptance
    a_r2_no_early_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !rsp_valid);

    // R5: a normal response carries the tag of the last accepted request
    a_r5_tag_echo: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err) |-> (rsp_tag == acc_tag_q));
endmodule

bind cache_mode_ctrl cmc_mode_ctrl_chk #(.TAG_W(TAG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_tag   (req_tag),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_tag   (rsp_tag)
);

// File: tb/cache_mode_ctrl_tb.sv
module cache_mode_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 11;
    localparam int DATA_W = 32;
    localparam int TAG_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cfg_valid;
    logic [1:0]        cfg_mode;
    logic              req_valid;
    logic              req_ready;
    logic              req_write;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata;
    logic [TAG_W-1:0]  req_tag;
    logic              rsp_valid;
    logic              rsp_err;
    logic [DATA_W-1:0] rsp_rdata;
    logic [TAG_W-1:0]  rsp_tag;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cache_mode_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_valid (cfg_valid),
        .cfg_mode  (cfg_mode),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_tag   (req_tag),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata),
        .rsp_tag   (rsp_tag)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Result of the last access: edges from acceptance to response (-1 if never
    // accepted), cycles waited with ready low, and whether ready was seen high
    // while the access was in flight.
    int               r_lat;
    int               r_wait;
    logic             r_busy_rdy;
    logic [DATA_W-1:0] r_data;
    logic             r_err;
    logic [TAG_W-1:0] r_tag;

    task automatic access(input logic we, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d, input logic [TAG_W-1:0] t,
                          input logic cfg_pulse, input logic [1:0] cfg_m);
        logic acc = 1'b0;
        int   cnt = 0;
        r_lat = -2; r_wait = 0; r_busy_rdy = 1'b0; r_data = '0; r_err = 1'b0; r_tag = '0;
        req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d; req_tag = t;
        if (cfg_pulse) begin
            cfg_valid = 1'b1; cfg_mode = cfg_m;
        end
        for (int i = 0; i < 60; i++) begin
            logic rdy = req_ready;
            if (acc && rdy) r_busy_rdy = 1'b1;
            @(negedge clk);
            cfg_valid = 1'b0;
            if (acc) cnt++;
            else if (rdy) begin
                acc = 1'b1; req_valid = 1'b0; cnt = 0;
            end else r_wait++;
            if (rsp_valid) begin
                r_lat = acc ? cnt : -1;
                r_data = rsp_rdata; r_err = rsp_err; r_tag = rsp_tag;
                req_valid = 1'b0;
                break;
            end
        end
        req_valid = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        cfg_valid = 1'b1; cfg_mode = m;
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 ready after reset", req_ready, 1);
        chk("R1 no response after reset", rsp_valid, 0);
    endtask

    task automatic t_fast;
        access(1'b1, 11'd5, 32'hA5A5_0001, 4'd3, 1'b0, 2'b00);
        chk("R2 fast write latency", r_lat, 2);
        chk("R5 write tag echo", r_tag, 3);
        chk("R5 write rdata zero", r_data, 0);
        chk("R4 ready low while busy", r_busy_rdy, 0);
        access(1'b0, 11'd5, 32'h0, 4'd7, 1'b0, 2'b00);
        chk("R4 ready back in response cycle", r_wait, 0);
        chk("R2 fast read latency", r_lat, 2);
        chk("R2 no error in fast", r_err, 0);
        chk("R5 read data", r_data, 32'hA5A5_0001);
        chk("R5 read tag echo", r_tag, 7);
        access(1'b0, 11'd9, 32'h0, 4'd1, 1'b0, 2'b00);
        chk("R11 unwritten word reads zero", r_data, 0);
    endtask

    task automatic t_slow;
        set_mode(2'b10);
        idle(5);
        access(1'b1, 11'd2047, 32'h1234_5678, 4'd9, 1'b0, 2'b00);
        chk("R3 slow write latency", r_lat, 4);
        access(1'b0, 11'd2047, 32'h0, 4'd10, 1'b0, 2'b00);
        chk("R3 slow read latency", r_lat, 4);
        chk("R3 slow read data", r_data, 32'h1234_5678);
    endtask

    task automatic t_blackout;
        set_mode(2'b01);
        access(1'b0, 11'd5, 32'h0, 4'd2, 1'b0, 2'b00);
        chk("R7 ready low three cycles", r_wait, 3);
        chk("R7 new fast latency", r_lat, 2);
        chk("R8 held request data", r_data, 32'hA5A5_0001);
        chk("R8 held request tag", r_tag, 2);
    endtask

    task automatic t_inflight;
        access(1'b0, 11'd5, 32'h0, 4'd4, 1'b1, 2'b10);
        chk("R9 in-flight keeps old latency", r_lat, 2);
        access(1'b0, 11'd5, 32'h0, 4'd5, 1'b0, 2'b00);
        chk("R9 blackout after response", r_wait, 3);
        chk("R9 new slow latency", r_lat, 4);
    endtask

    task automatic t_ignore;
        set_mode(2'b11);
        access(1'b0, 11'd5, 32'h0, 4'd6, 1'b0, 2'b00);
        chk("R10 code 11 no blackout", r_wait, 0);
        chk("R10 code 11 keeps slow latency", r_lat, 4);
    endtask

    task automatic t_off;
        access(1'b1, 11'd33, 32'hDEAD_BEEF, 4'd8, 1'b0, 2'b00);
        set_mode(2'b00);
        access(1'b0, 11'd33, 32'h0, 4'd11, 1'b0, 2'b00);
        chk("R6 off never accepts", r_lat, -1);
        chk("R6 off error flag", r_err, 1);
        chk("R6 off error tag", r_tag, 11);
        chk("R6 off error rdata", r_data, 0);
        access(1'b1, 11'd40, 32'h5555_AAAA, 4'd12, 1'b0, 2'b00);
        chk("R6 second off request error", r_err, 1);
        set_mode(2'b01);
        access(1'b0, 11'd33, 32'h0, 4'd13, 1'b0, 2'b00);
        chk("R11 contents invalid after off", r_data, 0);
        chk("R2 fast after re-enable", r_lat, 2);
    endtask

    initial begin
        rst_n = 1'b0; cfg_valid = 1'b0; cfg_mode = 2'b00;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_tag = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_fast();
        t_slow();
        t_blackout();
        t_inflight();
        t_ignore();
        t_off();
        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule